// File: doc/BRIEF.md
# Scratchpad-Staged Serial Memory Function Controller

This block is the memory-command layer of a single-wire serial memory slave. It receives bytes that a bit layer has already assembled, and it answers the bit layer's read slots one byte at a time. It holds a 32-byte staging scratchpad and a 512-byte array made of sixteen 32-byte pages, both modelled as registers. It also keeps a 16-bit target address and a status byte. The status byte records the last scratchpad offset that was written, a partial-byte flag and an authorization-accepted flag.

The host never writes the array directly. It fills the scratchpad first and reads it back to verify it. It then issues a copy command that must echo the target address and the status byte exactly. Only an exact echo moves the staged bytes into the array. A wrong echo, an unknown command, or a read slot outside a data phase yields all-ones bytes. Every session is closed by a reset indication from the bit layer.

Top module: `sp_eeprom_ctrl`

## Requirements
- R1: After rst_n is released, tx_byte reads 8'hFF, busy is low and the block waits for a command byte.
- R2: Command 8'h0F takes the low and then the high target address byte. It clears status bit 7 (authorization) and bit 5 (partial) as soon as it is taken. Each following data byte is stored at the next scratchpad offset, starting at target[4:0], and status[4:0] records the offset of the last complete byte.
- R3: Once write-scratchpad has stored offset 31, further data bytes are ignored: neither the scratchpad nor the status byte changes.
- R4: A bus reset with rx_partial high during the write-scratchpad data phase sets status bit 5.
- R5: Command 8'hAA returns, on successive tx_req, the low target byte, the high target byte, the status byte, and then scratchpad bytes from target[4:0] through status[4:0]. After that it returns 8'hFF.
- R6: Command 8'h55 followed by the low target byte, the high target byte and the status byte, all equal to the stored values, copies scratchpad offsets target[4:0]..status[4:0] to the array page target[8:5]. It sets status bit 7 and holds busy high for BUSY_CYC cycles. During busy, tx_byte reads 8'hFF; afterwards it reads 8'hAA.
- R7: A copy whose echoed bytes differ in any byte copies nothing and leaves status bit 7 clear. tx_byte reads 8'hFF until the next bus reset.
- R8: Command 8'hF0 takes two target address bytes and then returns array bytes from address target[8:0], incrementing on each tx_req and wrapping from 511 to 0.
- R9: An unrecognised command byte makes the block ignore received bytes and return 8'hFF until the next bus reset.
- R10: bus_reset returns the block to waiting for a command from any phase. Stored addresses, status and data are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | Reset indication from the bit layer, one cycle |
| rx_partial | input | 1 | With bus_reset: a byte was partly received |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Read slot byte consumed; advance to next byte |
| tx_byte | output | 8 | Byte to transmit in the current read slot |
| busy | output | 1 | Copy programming in progress |

## Verification
A received byte takes effect on the clock edge that samples rx_valid. The byte to transmit is driven combinationally from registered state, so it is valid from the edge after a strobe and changes only on the edge that samples tx_req. The bench drives and samples on the falling edge. It reads tx_byte before it pulses tx_req, so each comparison sees the byte for the current slot. The busy window opens on the edge that accepts the echoed status byte, and the bench counts it in whole cycles against BUSY_CYC.

// File: rtl/sp_eeprom_ctrl.sv
module sp_eeprom_ctrl #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYC   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_partial,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic [7:0] tx_byte,
  output logic       busy
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  typedef enum logic [4:0] {
    S_CMD, S_IGN, S_ONES,
    S_WS_A1, S_WS_A2, S_WS_D,
    S_RS_A1, S_RS_A2, S_RS_ES, S_RS_D,
    S_CP_A1, S_CP_A2, S_CP_ES, S_CP_RUN,
    S_RM_A1, S_RM_A2, S_RM_D
  } st_t;

  st_t               state;
  logic [15:0]       ta;
  logic [7:0]        es;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] ptr;
  logic              bad;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        sp  [PAGE_BYTES];
  logic [7:0]        mem [DEPTH];

  wire rx      = rx_valid && !bus_reset;
  wire tx      = tx_req && !bus_reset;
  wire do_copy = rx && state == S_CP_ES && !bad && rx_byte == es;
  wire sp_wr   = rx && state == S_WS_D;

  wire cmd_ph  = state == S_CMD;
  wire ws_ph   = state == S_WS_D;
  wire ones_ph = state == S_ONES;

  assign busy = cnt != '0;

  always_comb begin
    case (state)
      S_RS_A1:  tx_byte = ta[7:0];
      S_RS_A2:  tx_byte = ta[15:8];
      S_RS_ES:  tx_byte = es;
      S_RS_D:   tx_byte = sp[off];
      S_RM_D:   tx_byte = mem[ptr];
      S_CP_RUN: tx_byte = busy ? 8'hFF : 8'hAA;
      default:  tx_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_CMD;
      ta    <= '0;
      es    <= '0;
      off   <= '0;
      ptr   <= '0;
      bad   <= 1'b0;
      cnt   <= '0;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (bus_reset) begin
        if (state == S_WS_D && rx_partial) es[5] <= 1'b1;
        state <= S_CMD;
      end else begin
        case (state)
          S_CMD: if (rx) begin
            case (rx_byte)
              8'h0F: begin state <= S_WS_A1; es[7] <= 1'b0; es[5] <= 1'b0; end
              8'hAA: begin state <= S_RS_A1; off <= ta[OFF_W-1:0]; end
              8'h55: state <= S_CP_A1;
              8'hF0: state <= S_RM_A1;
              default: state <= S_IGN;
            endcase
          end
          S_WS_A1: if (rx) begin ta[7:0] <= rx_byte; state <= S_WS_A2; end
          S_WS_A2: if (rx) begin
            ta[15:8] <= rx_byte;
            off      <= ta[OFF_W-1:0];
            state    <= S_WS_D;
          end
          S_WS_D: if (rx) begin
            es[OFF_W-1:0] <= off;
            if (off == OFF_W'(PAGE_BYTES - 1)) state <= S_IGN;
            else off <= off + 1'b1;
          end
          S_RS_A1: if (tx) state <= S_RS_A2;
          S_RS_A2: if (tx) state <= S_RS_ES;
          S_RS_ES: if (tx) state <= S_RS_D;
          S_RS_D:  if (tx) begin
            if (off == es[OFF_W-1:0]) state <= S_ONES;
            else off <= off + 1'b1;
          end
          S_CP_A1: if (rx) begin bad <= rx_byte != ta[7:0]; state <= S_CP_A2; end
          S_CP_A2: if (rx) begin bad <= bad || rx_byte != ta[15:8]; state <= S_CP_ES; end
          S_CP_ES: if (rx) begin
            if (do_copy) begin
              es[7] <= 1'b1;
              cnt   <= CNT_W'(BUSY_CYC);
              state <= S_CP_RUN;
            end else begin
              state <= S_ONES;
            end
          end
          S_RM_A1: if (rx) begin ta[7:0] <= rx_byte; state <= S_RM_A2; end
          S_RM_A2: if (rx) begin
            ta[15:8] <= rx_byte;
            ptr      <= {rx_byte[ADDR_W-9:0], ta[7:0]};
            state    <= S_RM_D;
          end
          S_RM_D: if (tx) ptr <= ptr + 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sp_wr) sp[off] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_copy) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (OFF_W'(i) >= ta[OFF_W-1:0] && OFF_W'(i) <= es[OFF_W-1:0])
          mem[{ta[ADDR_W-1:OFF_W], OFF_W'(i)}] <= sp[i];
      end
    end
  end
endmodule

module sp_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic [7:0] tx_byte,
  input logic       busy,
  input logic [7:0] es,
  input logic       cmd_ph,
  input logic       ws_ph,
  input logic       ones_ph
);
  p_busy_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tx_byte == 8'hFF);

  p_auth_with_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es[7]) |-> $rose(busy));

  p_ws_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ph && rx_valid && !bus_reset && rx_byte == 8'h0F) |=> (!es[7] && !es[5]));

  p_es_off_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(es[4:0]) |-> $past(ws_ph && rx_valid));

  p_ones_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ones_ph |-> tx_byte == 8'hFF);

  p_partial_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es[5]) |-> $past(ws_ph && bus_reset));
endmodule

bind sp_eeprom_ctrl sp_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .tx_byte(tx_byte), .busy(busy), .es(es),
  .cmd_ph(cmd_ph), .ws_ph(ws_ph), .ones_ph(ones_ph)
);

// File: tb/sim_sp_eeprom_ctrl.sv
module sim_sp_eeprom_ctrl;
  localparam int BUSY_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, rx_partial = 1'b0;
  logic rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] tx_byte;
  logic busy;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] sp_m [32];
  logic [7:0] b;

  always #4 clk = ~clk;

  sp_eeprom_ctrl #(.BUSY_CYC(BUSY_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_partial(rx_partial),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_byte(tx_byte), .busy(busy)
  );

  // {ta1, ta2, count, seed}
  localparam logic [31:0] VEC [4] = '{
    32'h03_00_04_10, 32'h10_01_08_A0, 32'h00_00_01_5C, 32'h1C_00_04_33
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v);
    @(negedge clk); rx_valid = 1'b1; rx_byte = v;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pull(output logic [7:0] v);
    v = tx_byte; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic breset(input logic p);
    @(negedge clk); bus_reset = 1'b1; rx_partial = p;
    @(negedge clk); bus_reset = 1'b0; rx_partial = 1'b0;
  endtask

  task automatic wsp(input logic [7:0] a1, input logic [7:0] a2, input int n, input logic [7:0] seed);
    send(8'h0F); send(a1); send(a2);
    for (int i = 0; i < n; i++) begin
      send(8'(seed + i * 7));
      if (a1[4:0] + i < 32) sp_m[a1[4:0] + i] = 8'(seed + i * 7);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx idle", tx_byte, 8'hFF);
    check("R1 busy", {7'b0, busy}, 8'h00);

    // R2 / R5: vector table of write then read-back sessions
    for (int v = 0; v < 4; v++) begin
      logic [7:0] a1, a2, n, sd, last;
      {a1, a2, n, sd} = VEC[v];
      wsp(a1, a2, int'(n), sd);
      breset(1'b0);
      last = 8'(a1[4:0] + n - 1);
      send(8'hAA);
      pull(b); check("R5 ta1", b, a1);
      pull(b); check("R5 ta2", b, a2);
      pull(b); check("R2 status", b, last);
      for (int i = 0; i < int'(n); i++) begin
        pull(b); check("R2 R5 data", b, sp_m[a1[4:0] + i]);
      end
      pull(b); check("R5 trailing ones", b, 8'hFF);
      breset(1'b0);
    end

    // R3: overflow past offset 31 ignored
    wsp(8'h1E, 8'h00, 4, 8'h40);
    breset(1'b0);
    send(8'hAA);
    pull(b); pull(b);
    pull(b); check("R3 status stays 31", b, 8'h1F);
    pull(b); check("R3 off30 intact", b, 8'h40);
    pull(b); check("R3 off31", b, 8'h47);
    pull(b); check("R3 end", b, 8'hFF);
    breset(1'b0);

    // R4: partial byte flag
    wsp(8'h02, 8'h00, 2, 8'h21);
    breset(1'b1);
    send(8'hAA);
    pull(b); pull(b);
    pull(b); check("R4 partial flag", b, 8'h23);
    breset(1'b0);

    // R6: copy success to address 511
    wsp(8'hFF, 8'h01, 1, 8'hC3);
    breset(1'b0);
    send(8'h55); send(8'hFF); send(8'h01); send(8'h1F);
    begin
      int n = 0;
      check("R6 ones while busy", tx_byte, 8'hFF);
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check("R6 busy length", 8'(n), 8'(BUSY_CYC));
    end
    check("R6 done pattern", tx_byte, 8'hAA);
    breset(1'b0);
    send(8'hAA);
    pull(b); pull(b);
    pull(b); check("R6 auth flag", b, 8'h9F);
    breset(1'b0);

    // R6: copy into page 0
    wsp(8'h00, 8'h00, 2, 8'h11);
    breset(1'b0);
    send(8'h55); send(8'h00); send(8'h00); send(8'h01);
    repeat (BUSY_CYC + 1) @(negedge clk);
    breset(1'b0);

    // R8: read memory with wrap
    send(8'hF0); send(8'hFF); send(8'h01);
    pull(b); check("R8 addr 511", b, 8'hC3);
    pull(b); check("R8 wrap to 0", b, 8'h11);
    pull(b); check("R8 addr 1", b, 8'h18);
    breset(1'b0);

    // R7: mismatch
    wsp(8'h00, 8'h00, 1, 8'h99);
    breset(1'b0);
    send(8'h55); send(8'h00); send(8'h00); send(8'h05);
    check("R7 busy stays low", {7'b0, busy}, 8'h00);
    pull(b); check("R7 ones", b, 8'hFF);
    pull(b); check("R7 ones again", b, 8'hFF);
    breset(1'b0);
    send(8'hAA);
    pull(b); pull(b);
    pull(b); check("R7 auth clear", b, 8'h00);
    breset(1'b0);
    send(8'hF0); send(8'h00); send(8'h00);
    pull(b); check("R7 no copy", b, 8'h11);
    breset(1'b0);

    // R9: unknown command, then R10 recovery
    send(8'h3C); send(8'hAA);
    check("R9 ignored", tx_byte, 8'hFF);
    breset(1'b0);
    send(8'hF0); send(8'h01); send(8'h00);
    pull(b); check("R10 after reset", b, 8'h18);
    breset(1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule